// File: doc/BRIEF.md
# QoS Identifier CSR Unit

This unit holds the quality-of-service tags of one hart. A supervisor-level configuration register carries two 12-bit identifiers. The first is a resource-control ID, which later hardware uses to pick an allocation class. The second is a monitoring-counter ID, which picks a usage-counting bucket. A machine-level state-enable register decides whether supervisor software may reach that configuration register. The unit serves a plain CSR port: address, read enable, write enable, write data, the current privilege level and the XLEN mode. It answers with read data and an illegal-access flag.

Read data and the flag are combinational from the request. Writes take effect at the next rising clock edge. The hart's trap logic turns the flag into an exception. Two static parameters say whether the QoS extension and the state-enable extension are built in. A second instance with other parameter values gives a different access policy with the same ports. The unit claims only its own three addresses and flags every other address, so the flag means that this unit cannot serve the access.

Top module: `qos_csr_unit`

## Requirements
- R1: A permitted read of address 0x181 returns the resource-control ID in bits 11:0 and the monitoring-counter ID in bits 27:16. Every other bit of the 64-bit read data is zero.
- R2: A permitted write to 0x181 loads write-data bits 11:0 into the resource-control ID and bits 27:16 into the monitoring-counter ID, and discards all other bits. The new value is read back from the cycle after the write edge.
- R3: Reset (rst_n low, asynchronous) clears both IDs and the state-enable register to zero.
- R4: With the QoS extension present, machine privilege (priv = 2'b11) may always read and write 0x181.
- R5: Supervisor privilege (priv = 2'b01) may access 0x181 when the state-enable extension is absent. When it is present, supervisor access needs state-enable bit 55 to be 1; otherwise the access is illegal.
- R6: User privilege (priv = 2'b00) and the reserved level 2'b10 are always refused at 0x181.
- R7: The state-enable register is reachable only at machine privilege and only when the state-enable extension is present. Only bit 55 is writable, and only when the QoS extension is present. All other bits read zero.
- R8: With 32-bit XLEN (xlen64 = 0), 0x30C reads the low half of the state-enable register and 0x31C reads the high half, where bit 55 appears as bit 23. Read data bits 63:32 are zero. A write to one half leaves the other half unchanged.
- R9: With 64-bit XLEN (xlen64 = 1), 0x30C reaches the whole state-enable register, with bit 55 read and written in place. Any access to 0x31C is illegal.
- R10: An access that is not permitted raises csr_illegal, returns zero read data and changes no state. This includes any address other than 0x181, 0x30C and 0x31C. Read data is zero whenever no permitted read is under way.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_addr | input | 12 | CSR address of the access |
| csr_re | input | 1 | Read request |
| csr_we | input | 1 | Write request |
| csr_wdata | input | 64 | Write data |
| csr_priv | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| csr_xlen64 | input | 1 | 1 selects 64-bit XLEN, 0 selects 32-bit |
| csr_rdata | output | 64 | Read data, zero unless a permitted read |
| csr_illegal | output | 1 | Access refused by this unit |

## Verification
Read data and the illegal flag depend only on the current request and the stored state, so they are due in the same cycle the request is driven. A write changes the stored state at the next rising edge, and its effect is due on the first request after that edge. The bench drives each request at the falling edge and samples one time unit later, before the rising edge. It updates its reference model only after that sample, so every later request is checked against state that already includes the write. A copy of the unit without the state-enable extension runs on the same inputs to cover the second supervisor rule.

// File: rtl/qos_csr_pkg.sv
package qos_csr_pkg;

   typedef enum logic [1:0] {
      PRIV_U   = 2'd0,
      PRIV_S   = 2'd1,
      PRIV_RSV = 2'd2,
      PRIV_M   = 2'd3
   } priv_e;

   localparam logic [11:0] CSR_QOS_CFG = 12'h181;
   localparam logic [11:0] CSR_SEN_LO  = 12'h30C;
   localparam logic [11:0] CSR_SEN_HI  = 12'h31C;

   // position of the supervisor QoS gate inside the state-enable register
   localparam int SEN_QOS_BIT = 55;

   typedef struct packed {
      logic qos;
      logic sen_lo;
      logic sen_hi;
   } csr_sel_t;

endpackage

// File: rtl/qos_csr_access.sv
module qos_csr_access
   import qos_csr_pkg::*;
#(
   parameter bit HAS_QOS     = 1'b1,
   parameter bit HAS_STATEEN = 1'b1
) (
   input  logic [11:0] addr,
   input  logic [1:0]  priv,
   input  logic        xlen64,
   input  logic        gate,
   input  logic        access,
   output csr_sel_t    sel,
   output logic        illegal
);

   logic qos_ok;
   logic sen_ok;

   always_comb begin
      qos_ok = HAS_QOS &&
               ((priv == PRIV_M) ||
                ((priv == PRIV_S) && (!HAS_STATEEN || gate)));
      sen_ok = HAS_STATEEN && (priv == PRIV_M);

      sel.qos    = (addr == CSR_QOS_CFG) && qos_ok;
      sel.sen_lo = (addr == CSR_SEN_LO) && sen_ok;
      sel.sen_hi = (addr == CSR_SEN_HI) && sen_ok && !xlen64;

      illegal = access && !(|sel);
   end

endmodule

// File: rtl/qos_id_fields.sv
module qos_id_fields #(
   parameter int RCID_W   = 12,
   parameter int MCID_W   = 12,
   parameter int MCID_LSB = 16,
   parameter int DATA_W   = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [RCID_W-1:0] rcid_d,
   input  logic [MCID_W-1:0] mcid_d,
   output logic [RCID_W-1:0] rcid_q,
   output logic [MCID_W-1:0] mcid_q,
   output logic [DATA_W-1:0] image
);

   if (RCID_W > MCID_LSB) begin : g_bad_overlap
      $error("qos_id_fields: resource-control field overlaps monitoring field");
   end
   if (MCID_LSB + MCID_W > DATA_W) begin : g_bad_width
      $error("qos_id_fields: monitoring field exceeds data width");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rcid_q <= '0;
         mcid_q <= '0;
      end else if (wr_en) begin
         rcid_q <= rcid_d;
         mcid_q <= mcid_d;
      end
   end

   always_comb begin
      image = '0;
      image[RCID_W-1:0] = rcid_q;
      image[MCID_LSB +: MCID_W] = mcid_q;
   end

endmodule

// File: rtl/qos_sen_gate.sv
module qos_sen_gate #(
   parameter bit ENABLE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_full,
   input  logic bit_full,
   input  logic wr_hi,
   input  logic bit_hi,
   output logic gate
);

   if (ENABLE) begin : g_flop
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       gate <= 1'b0;
         else if (wr_full) gate <= bit_full;
         else if (wr_hi)   gate <= bit_hi;
      end

      a_r7_gate_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
         wr_full |=> (gate == $past(bit_full)));
      a_r8_gate_follows_high_half: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_hi && !wr_full) |=> (gate == $past(bit_hi)));
   end else begin : g_zero
      logic unused_gate_in;
      assign unused_gate_in = ^{clk, rst_n, wr_full, bit_full, wr_hi, bit_hi};
      assign gate = 1'b0;
   end

endmodule

// File: rtl/qos_csr_unit.sv
module qos_csr_unit
   import qos_csr_pkg::*;
#(
   parameter bit HAS_QOS     = 1'b1,
   parameter bit HAS_STATEEN = 1'b1,
   parameter int RCID_W      = 12,
   parameter int MCID_W      = 12,
   parameter int MCID_LSB    = 16,
   parameter int DATA_W      = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [11:0]       csr_addr,
   input  logic              csr_re,
   input  logic              csr_we,
   input  logic [DATA_W-1:0] csr_wdata,
   input  logic [1:0]        csr_priv,
   input  logic              csr_xlen64,
   output logic [DATA_W-1:0] csr_rdata,
   output logic              csr_illegal
);

   localparam int HALF_W = DATA_W / 2;
   localparam int GATE_HI_BIT = SEN_QOS_BIT - HALF_W;
   localparam logic [DATA_W-1:0] FIELD_MASK =
      ((DATA_W'(1) << RCID_W) - 1) | (((DATA_W'(1) << MCID_W) - 1) << MCID_LSB);

   if (DATA_W != 64) begin : g_bad_data_w
      $error("qos_csr_unit: data width must be 64");
   end

   csr_sel_t          sel;
   logic              gate;
   logic [RCID_W-1:0] rcid;
   logic [MCID_W-1:0] mcid;
   logic [DATA_W-1:0] qos_image;
   logic [DATA_W-1:0] sen_image;
   logic              wr_qos;
   logic              wr_full;
   logic              wr_hi;
   logic              unused_wdata;

   assign unused_wdata = ^csr_wdata;

   qos_csr_access #(
      .HAS_QOS     (HAS_QOS),
      .HAS_STATEEN (HAS_STATEEN)
   ) u_access (
      .addr    (csr_addr),
      .priv    (csr_priv),
      .xlen64  (csr_xlen64),
      .gate    (gate),
      .access  (csr_re | csr_we),
      .sel     (sel),
      .illegal (csr_illegal)
   );

   assign wr_qos  = csr_we && sel.qos;
   assign wr_full = csr_we && sel.sen_lo && csr_xlen64;
   assign wr_hi   = csr_we && sel.sen_hi;

   qos_id_fields #(
      .RCID_W   (RCID_W),
      .MCID_W   (MCID_W),
      .MCID_LSB (MCID_LSB),
      .DATA_W   (DATA_W)
   ) u_ids (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_qos),
      .rcid_d (csr_wdata[RCID_W-1:0]),
      .mcid_d (csr_wdata[MCID_LSB +: MCID_W]),
      .rcid_q (rcid),
      .mcid_q (mcid),
      .image  (qos_image)
   );

   qos_sen_gate #(
      .ENABLE (HAS_QOS && HAS_STATEEN)
   ) u_gate (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_full  (wr_full),
      .bit_full (csr_wdata[SEN_QOS_BIT]),
      .wr_hi    (wr_hi),
      .bit_hi   (csr_wdata[GATE_HI_BIT]),
      .gate     (gate)
   );

   always_comb begin
      sen_image = '0;
      sen_image[SEN_QOS_BIT] = gate;
   end

   always_comb begin
      csr_rdata = '0;
      if (csr_re) begin
         if (sel.qos)
            csr_rdata = qos_image;
         else if (sel.sen_lo)
            csr_rdata = csr_xlen64 ? sen_image : {{HALF_W{1'b0}}, sen_image[HALF_W-1:0]};
         else if (sel.sen_hi)
            csr_rdata = {{HALF_W{1'b0}}, sen_image[DATA_W-1:HALF_W]};
      end
   end

   // R1: permitted reads of the QoS register show only the two ID fields
   a_r1_read_gaps_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_re && !csr_illegal && csr_addr == CSR_QOS_CFG) |-> ((csr_rdata & ~FIELD_MASK) == '0));

   a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_we && !csr_illegal && csr_addr == CSR_QOS_CFG) |=>
      (rcid == $past(csr_wdata[RCID_W-1:0]) && mcid == $past(csr_wdata[MCID_LSB +: MCID_W])));

   a_r4_machine_allowed: assert property (@(posedge clk) disable iff (!rst_n)
      (HAS_QOS && (csr_re || csr_we) && csr_priv == PRIV_M && csr_addr == CSR_QOS_CFG) |-> !csr_illegal);

   a_r5_supervisor_gated: assert property (@(posedge clk) disable iff (!rst_n)
      (HAS_STATEEN && !gate && (csr_re || csr_we) && csr_priv == PRIV_S &&
       csr_addr == CSR_QOS_CFG) |-> csr_illegal);

   a_r6_user_refused: assert property (@(posedge clk) disable iff (!rst_n)
      ((csr_re || csr_we) && (csr_priv == PRIV_U || csr_priv == PRIV_RSV) &&
       csr_addr == CSR_QOS_CFG) |-> csr_illegal);

   a_r8_low_half_keeps_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_we && !csr_xlen64 && csr_addr == CSR_SEN_LO) |=> $stable(gate));

   a_r9_high_half_hidden: assert property (@(posedge clk) disable iff (!rst_n)
      ((csr_re || csr_we) && csr_xlen64 && csr_addr == CSR_SEN_HI) |-> csr_illegal);

   a_r10_illegal_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      csr_illegal |-> (csr_rdata == '0));

   a_r10_illegal_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_we && csr_illegal) |=> ($stable(rcid) && $stable(mcid) && $stable(gate)));

endmodule

// File: tb/sim_qos_csr_unit.sv
module sim_qos_csr_unit;

   localparam int CLK_PERIOD = 10;
   localparam int N_RANDOM   = 800;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] csr_addr = '0;
   logic        csr_re = 1'b0;
   logic        csr_we = 1'b0;
   logic [63:0] csr_wdata = '0;
   logic [1:0]  csr_priv = 2'd3;
   logic        csr_xlen64 = 1'b1;
   logic [63:0] rd0, rd1;
   logic        ill0, ill1;

   int checks = 0;
   int failures = 0;

   // reference state: u0 (both extensions), u1 (no state-enable extension)
   logic [11:0] m_rcid, m_mcid, n_rcid, n_mcid;
   logic        m_gate;

   always #(CLK_PERIOD/2) clk = ~clk;

   qos_csr_unit u0 (
      .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_re(csr_re), .csr_we(csr_we),
      .csr_wdata(csr_wdata), .csr_priv(csr_priv), .csr_xlen64(csr_xlen64),
      .csr_rdata(rd0), .csr_illegal(ill0)
   );

   qos_csr_unit #(.HAS_STATEEN(1'b0)) u1 (
      .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_re(csr_re), .csr_we(csr_we),
      .csr_wdata(csr_wdata), .csr_priv(csr_priv), .csr_xlen64(csr_xlen64),
      .csr_rdata(rd1), .csr_illegal(ill1)
   );

   function automatic bit legal_f(bit sten, bit g, logic [11:0] a, logic [1:0] p, bit x64);
      if (a == 12'h181) return (p == 2'd3) || (p == 2'd1 && (!sten || g));
      if (a == 12'h30C) return sten && p == 2'd3;
      if (a == 12'h31C) return sten && p == 2'd3 && !x64;
      return 1'b0;
   endfunction

   function automatic logic [63:0] rd_f(bit g, logic [11:0] rc, logic [11:0] mc,
                                        logic [11:0] a, bit x64);
      if (a == 12'h181) return {36'd0, mc, 4'd0, rc};
      if (a == 12'h30C) return x64 ? (64'(g) << 55) : 64'd0;
      if (a == 12'h31C) return 64'(g) << 23;
      return 64'd0;
   endfunction

   task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      csr_re = 1'b0;
      csr_we = 1'b0;
      rst_n = 1'b0;
      m_rcid = '0; m_mcid = '0; m_gate = 1'b0;
      n_rcid = '0; n_mcid = '0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic step(string tag, logic [11:0] a, bit re, bit we, logic [1:0] p,
                       bit x64, logic [63:0] wd);
      bit l0, l1;
      @(negedge clk);
      csr_addr = a; csr_re = re; csr_we = we; csr_priv = p;
      csr_xlen64 = x64; csr_wdata = wd;
      #1;
      l0 = legal_f(1'b1, m_gate, a, p, x64);
      l1 = legal_f(1'b0, 1'b0, a, p, x64);
      chk(tag, "u0 rdata", rd0, (re && l0) ? rd_f(m_gate, m_rcid, m_mcid, a, x64) : 64'd0);
      chk(tag, "u0 illegal", 64'(ill0), 64'((re || we) && !l0));
      chk(tag, "u1 rdata", rd1, (re && l1) ? rd_f(1'b0, n_rcid, n_mcid, a, x64) : 64'd0);
      chk(tag, "u1 illegal", 64'(ill1), 64'((re || we) && !l1));
      if (we && l0) begin
         if (a == 12'h181) begin m_rcid = wd[11:0]; m_mcid = wd[27:16]; end
         else if (a == 12'h30C && x64) m_gate = wd[55];
         else if (a == 12'h31C) m_gate = wd[23];
      end
      if (we && l1 && a == 12'h181) begin n_rcid = wd[11:0]; n_mcid = wd[27:16]; end
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      void'($urandom(32'd2024));
      do_reset();
      // R3: reset state
      step("R3", 12'h181, 1, 0, 2'd3, 1, '0);
      step("R3", 12'h30C, 1, 0, 2'd3, 1, '0);
      // R2 R4: machine write with all ones, only fields stick
      step("R2", 12'h181, 0, 1, 2'd3, 1, '1);
      step("R1", 12'h181, 1, 0, 2'd3, 1, '0);
      step("R2", 12'h181, 1, 1, 2'd3, 0, 64'h0000_0000_0ABC_0123);
      step("R4", 12'h181, 1, 0, 2'd3, 0, '0);
      // R5: supervisor blocked on u0 while gate is zero, allowed on u1
      step("R5", 12'h181, 1, 0, 2'd1, 1, '0);
      step("R5", 12'h181, 0, 1, 2'd1, 1, 64'h0000_0000_0555_0AAA);
      step("R5", 12'h181, 1, 0, 2'd3, 1, '0);
      // R6: user and reserved levels refused, nothing changes
      step("R6", 12'h181, 1, 1, 2'd0, 1, 64'h0FFF_0FFF);
      step("R6", 12'h181, 1, 1, 2'd2, 1, 64'h0FFF_0FFF);
      step("R10", 12'h181, 1, 0, 2'd3, 1, '0);
      // R7: only bit 55 writable, machine only
      step("R7", 12'h30C, 0, 1, 2'd3, 1, '1);
      step("R7", 12'h30C, 1, 0, 2'd3, 1, '0);
      step("R7", 12'h30C, 1, 1, 2'd1, 1, '0);
      step("R5", 12'h181, 1, 1, 2'd1, 1, 64'h0000_0000_0777_0111);
      step("R5", 12'h181, 1, 0, 2'd1, 1, '0);
      // R8: 32-bit halves
      step("R8", 12'h31C, 1, 0, 2'd3, 0, '0);
      step("R8", 12'h30C, 1, 1, 2'd3, 0, 64'h0);
      step("R8", 12'h31C, 1, 0, 2'd3, 0, '0);
      step("R8", 12'h31C, 0, 1, 2'd3, 0, 64'hFFFF_FFFF_FF7F_FFFF);
      step("R8", 12'h31C, 1, 0, 2'd3, 0, '0);
      step("R8", 12'h31C, 0, 1, 2'd3, 0, 64'h0000_0000_0080_0000);
      step("R8", 12'h30C, 1, 0, 2'd3, 0, '0);
      // R9: 64-bit mode hides the high-half address
      step("R9", 12'h31C, 1, 1, 2'd3, 1, '0);
      step("R9", 12'h30C, 1, 0, 2'd3, 1, '0);
      // R10: foreign addresses
      step("R10", 12'h180, 1, 1, 2'd3, 1, '1);
      step("R10", 12'h182, 1, 0, 2'd1, 1, '0);
      step("R10", 12'h181, 0, 0, 2'd3, 1, '1);
      // R3: reset after writes clears everything
      step("R3", 12'h181, 0, 1, 2'd3, 1, 64'h0123_0456);
      do_reset();
      step("R3", 12'h181, 1, 0, 2'd3, 1, '0);
      step("R3", 12'h30C, 1, 0, 2'd3, 1, '0);
      step("R3", 12'h181, 1, 0, 2'd1, 1, '0);
      // random traffic
      for (int i = 0; i < N_RANDOM; i++) begin
         int sel = $urandom_range(0, 3);
         logic [11:0] a;
         string tag;
         case (sel)
            0: begin a = 12'h181; tag = "R1"; end
            1: begin a = 12'h30C; tag = "R7"; end
            2: begin a = 12'h31C; tag = "R8"; end
            default: begin a = 12'($urandom_range(0, 4095)); tag = "R10"; end
         endcase
         step(tag, a, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
              2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), {$urandom, $urandom});
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule